// File: doc/BRIEF.md
# Conditional Jump and Subroutine Link Sequencer

This block holds the program counter of a 24-bit, word-addressed accumulator machine and chooses where the next instruction fetch comes from. It requests a fetch at the address in the counter, waits for the instruction word, and splits that word into a function code, a shift count and an address field. It then looks at the accumulator and quotient register values it is given and either steps to the next word or loads the address field into the counter.

Five function codes change the flow. Two of them jump when a register holds no set bits. Two of them jump on the sign of the accumulator. The fifth calls a subroutine: it stores the return address into the word at the target location, and execution resumes one word past that location. The routine can then leave through an indirect path that reads the stored word. Arithmetic, memory timing and I/O sit outside this block.

Top module: `branch_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `fetch_req` is 1, `fetch_addr` is 0 and `mem_we` is 0.
- R2: An accepted instruction word is split as function code = bits 23..18, shift count = bits 17..12, address field = bits 11..0. The shift count never affects the next address or the link write.
- R3: For any function code other than octal 42, 43, 44, 45 and 47, the next fetch address is the current one plus one, wrapping from 4095 to 0.
- R4: Function code octal 42 jumps to the address field when the accumulator is all zero, and otherwise continues at the current address plus one.
- R5: Function code octal 45 jumps to the address field when the quotient register is all zero, and otherwise continues at the current address plus one.
- R6: Function code octal 43 jumps to the address field when accumulator bit 23 is 0, and otherwise continues at the current address plus one.
- R7: Function code octal 44 jumps to the address field when accumulator bit 23 is 1, and otherwise continues at the current address plus one.
- R8: Function code octal 47 pulses `mem_we` for one cycle, in the cycle after acceptance. In that cycle `mem_addr` is the address field and `mem_wdata` is the current fetch address plus one in bits 11..0, with zeros above. The next fetch address is the address field plus one, wrapping to 0.
- R9: `mem_we` is high only for function code 47, and it is never high in the same cycle as `fetch_req`.
- R10: `fetch_req` is a one-cycle pulse. After the pulse the block holds `fetch_addr` and waits for `instr_valid`. The block ignores `instr_valid` in the pulse cycle and in the link-write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | output | 1 | One-cycle request to read the word at `fetch_addr` |
| fetch_addr | output | 12 | Current program counter |
| instr_valid | input | 1 | `instr` holds the fetched word |
| instr | input | 24 | Fetched instruction word |
| acc | input | 24 | Accumulator value |
| quo | input | 24 | Quotient register value |
| mem_we | output | 1 | Link write strobe |
| mem_addr | output | 12 | Link write address |
| mem_wdata | output | 24 | Link write data |

## Verification
Each conditional code is driven with register values that are exactly zero, nonzero only in the sign bit, nonzero only in bit 0, and random. These patterns separate a zero test from a sign test, and an accumulator test from a quotient test. Directed words with nonzero shift counts, and with a control code placed in the shift field, show that only bits 23..18 select the operation. Jumps and calls aimed at address 4095 show the counter wrapping. A word presented during the request pulse tells apart a design that samples only in its wait state. Random words with random acceptance latency mix all of this with the sequential step.

// File: rtl/brseq_pkg.sv
package brseq_pkg;

    localparam int WORD_W = 24;
    localparam int ADDR_W = 12;
    localparam int FN_W   = 6;
    localparam int SH_W   = 6;

    typedef logic [FN_W-1:0] fn_t;

    localparam fn_t FN_JMP_ACC_ZERO = 6'o42;
    localparam fn_t FN_JMP_POS      = 6'o43;
    localparam fn_t FN_JMP_NEG      = 6'o44;
    localparam fn_t FN_JMP_QUO_ZERO = 6'o45;
    localparam fn_t FN_CALL_LINK    = 6'o47;

    typedef enum logic [2:0] {
        OP_STEP,
        OP_ACC_ZERO,
        OP_QUO_ZERO,
        OP_POS,
        OP_NEG,
        OP_CALL
    } op_e;

    typedef enum logic [1:0] {
        ST_REQ,
        ST_WAIT,
        ST_LINK
    } st_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] target;
    } dec_t;

    function automatic op_e classify(input fn_t f);
        case (f)
            FN_JMP_ACC_ZERO: return OP_ACC_ZERO;
            FN_JMP_QUO_ZERO: return OP_QUO_ZERO;
            FN_JMP_POS:      return OP_POS;
            FN_JMP_NEG:      return OP_NEG;
            FN_CALL_LINK:    return OP_CALL;
            default:         return OP_STEP;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] next_word(input logic [ADDR_W-1:0] a);
        return a + 1'b1;
    endfunction

    function automatic logic [WORD_W-1:0] link_word(input logic [ADDR_W-1:0] a);
        return {{(WORD_W-ADDR_W){1'b0}}, a};
    endfunction

endpackage

// File: rtl/brseq_decode.sv
module brseq_decode
    import brseq_pkg::*;
#(
    parameter int P_WORD_W = WORD_W,
    parameter int P_FN_W   = FN_W,
    parameter int P_SH_W   = SH_W,
    parameter int P_ADDR_W = ADDR_W
) (
    input  logic [P_WORD_W-1:0] word,
    output dec_t                dec
);
    localparam int FN_LSB = P_SH_W + P_ADDR_W;
    localparam int SH_LSB = P_ADDR_W;

    logic [P_FN_W-1:0]   fn_f;
    logic [P_SH_W-1:0]   sh_f;
    logic [P_ADDR_W-1:0] ad_f;
    logic                unused_shift;

    assign fn_f = word[FN_LSB +: P_FN_W];
    assign sh_f = word[SH_LSB +: P_SH_W];
    assign ad_f = word[0 +: P_ADDR_W];

    // the shift count is carried by the word but plays no part in sequencing
    assign unused_shift = ^sh_f;

    always_comb begin
        dec.op     = classify(fn_f);
        dec.target = ad_f;
    end

    initial begin
        a_split_r2: assert (P_WORD_W == P_FN_W + P_SH_W + P_ADDR_W)
            else $error("instruction field widths do not add up to the word width");
    end
endmodule

// File: rtl/brseq_cond.sv
module brseq_cond
    import brseq_pkg::*;
#(
    parameter int P_WORD_W = WORD_W
) (
    input  op_e                 op,
    input  logic [P_WORD_W-1:0] acc,
    input  logic [P_WORD_W-1:0] quo,
    output logic                take
);
    logic acc_zero;
    logic quo_zero;
    logic acc_neg;

    assign acc_zero = (acc == '0);
    assign quo_zero = (quo == '0);
    assign acc_neg  = acc[P_WORD_W-1];

    always_comb begin
        unique case (op)
            OP_ACC_ZERO: take = acc_zero;
            OP_QUO_ZERO: take = quo_zero;
            OP_POS:      take = ~acc_neg;
            OP_NEG:      take = acc_neg;
            default:     take = 1'b0;
        endcase
    end
endmodule

// File: rtl/brseq_pc.sv
module brseq_pc
    import brseq_pkg::*;
#(
    parameter int P_ADDR_W = ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                upd,
    input  logic                take,
    input  logic                call,
    input  logic [P_ADDR_W-1:0] target,
    output logic [P_ADDR_W-1:0] pc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (upd) begin
            if (call)
                pc <= target + 1'b1;
            else if (take)
                pc <= target;
            else
                pc <= pc + 1'b1;
        end
    end

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (upd && !take && !call) |=> pc == $past(pc) + 1'b1);

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (upd && !take && !call && (&pc)) |=> pc == '0);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(pc));
endmodule

// File: rtl/branch_seq.sv
module branch_seq
    import brseq_pkg::*;
#(
    parameter int P_WORD_W = WORD_W,
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_FN_W   = FN_W,
    parameter int P_SH_W   = SH_W
) (
    input  logic                clk,
    input  logic                rst,
    output logic                fetch_req,
    output logic [P_ADDR_W-1:0] fetch_addr,
    input  logic                instr_valid,
    input  logic [P_WORD_W-1:0] instr,
    input  logic [P_WORD_W-1:0] acc,
    input  logic [P_WORD_W-1:0] quo,
    output logic                mem_we,
    output logic [P_ADDR_W-1:0] mem_addr,
    output logic [P_WORD_W-1:0] mem_wdata
);
    localparam int FN_LSB = P_SH_W + P_ADDR_W;

    st_e                 st;
    dec_t                dec;
    logic                accept;
    logic                take;
    logic                is_call;
    logic [P_ADDR_W-1:0] pc;
    logic [P_ADDR_W-1:0] lnk_addr;
    logic [P_ADDR_W-1:0] lnk_ret;

    brseq_decode #(
        .P_WORD_W(P_WORD_W), .P_FN_W(P_FN_W), .P_SH_W(P_SH_W), .P_ADDR_W(P_ADDR_W)
    ) u_dec (
        .word(instr),
        .dec (dec)
    );

    brseq_cond #(.P_WORD_W(P_WORD_W)) u_cond (
        .op  (dec.op),
        .acc (acc),
        .quo (quo),
        .take(take)
    );

    assign accept  = (st == ST_WAIT) && instr_valid;
    assign is_call = (dec.op == OP_CALL);

    brseq_pc #(.P_ADDR_W(P_ADDR_W)) u_pc (
        .clk   (clk),
        .rst   (rst),
        .upd   (accept),
        .take  (take),
        .call  (is_call),
        .target(dec.target),
        .pc    (pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_REQ;
        end else begin
            unique case (st)
                ST_REQ:  st <= ST_WAIT;
                ST_WAIT: if (accept) st <= is_call ? ST_LINK : ST_REQ;
                default: st <= ST_REQ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lnk_addr <= '0;
            lnk_ret  <= '0;
        end else if (accept && is_call) begin
            lnk_addr <= dec.target;
            lnk_ret  <= next_word(pc);
        end
    end

    assign fetch_req  = (st == ST_REQ);
    assign fetch_addr = pc;
    assign mem_we     = (st == ST_LINK);
    assign mem_addr   = lnk_addr;
    assign mem_wdata  = {{(P_WORD_W-P_ADDR_W){1'b0}}, lnk_ret};

    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && fetch_req));

    p_we_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (!mem_we && fetch_req));

    p_we_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |-> ($past(instr_valid) &&
                           $past(instr[FN_LSB +: P_FN_W]) == FN_CALL_LINK));

    p_link_r8: assert property (@(posedge clk) disable iff (rst)
        (accept && instr[FN_LSB +: P_FN_W] == FN_CALL_LINK) |=>
            (mem_we && mem_addr == $past(instr[P_ADDR_W-1:0]) &&
             mem_wdata[P_ADDR_W-1:0] == $past(fetch_addr) + 1'b1 &&
             fetch_addr == $past(instr[P_ADDR_W-1:0]) + 1'b1));

    p_req_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        fetch_req |=> (!fetch_req && $stable(fetch_addr)));

    p_acc_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && instr[FN_LSB +: P_FN_W] == FN_JMP_ACC_ZERO && acc == '0) |=>
            fetch_addr == $past(instr[P_ADDR_W-1:0]));

    p_neg_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && instr[FN_LSB +: P_FN_W] == FN_JMP_NEG && acc[P_WORD_W-1]) |=>
            fetch_addr == $past(instr[P_ADDR_W-1:0]));

    p_quo_nz_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && instr[FN_LSB +: P_FN_W] == FN_JMP_QUO_ZERO && quo != '0) |=>
            fetch_addr == $past(fetch_addr) + 1'b1);
endmodule

// File: tb/tb_branch_seq.sv
module tb_branch_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_req;
    logic [11:0] fetch_addr;
    logic        instr_valid;
    logic [23:0] instr;
    logic [23:0] acc;
    logic [23:0] quo;
    logic        mem_we;
    logic [11:0] mem_addr;
    logic [23:0] mem_wdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [11:0] model_pc;

    always #10 clk = ~clk;

    branch_seq dut (
        .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .instr_valid(instr_valid), .instr(instr), .acc(acc), .quo(quo),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL R10 watchdog expired: actual %0d cycles expected fewer", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] model_next(input logic [23:0] w, input logic [23:0] a,
                                               input logic [23:0] q, input logic [11:0] pc);
        logic [5:0]  fn;
        logic [11:0] t;
        logic [11:0] inc;
        fn  = w[23:18];
        t   = w[11:0];
        inc = pc + 12'd1;
        case (fn)
            6'o42:   return (a == 24'd0) ? t : inc;
            6'o45:   return (q == 24'd0) ? t : inc;
            6'o43:   return (!a[23]) ? t : inc;
            6'o44:   return (a[23]) ? t : inc;
            6'o47:   return t + 12'd1;
            default: return inc;
        endcase
    endfunction

    function automatic string req_of(input logic [5:0] fn);
        case (fn)
            6'o42:   return "R4";
            6'o45:   return "R5";
            6'o43:   return "R6";
            6'o44:   return "R7";
            6'o47:   return "R8";
            default: return "R3";
        endcase
    endfunction

    // called at a negedge inside the wait state
    task automatic drive_collect(input logic [23:0] w, input logic [23:0] a,
                                 input logic [23:0] q, input string tag);
        logic [11:0] exp_pc;
        bit          is_call;
        bit          saw_we;
        int          guard;
        exp_pc  = model_next(w, a, q, model_pc);
        is_call = (w[23:18] == 6'o47);
        saw_we  = 1'b0;
        acc = a; quo = q; instr = w; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        instr = $urandom;
        guard = 0;
        while (!fetch_req && guard < 8) begin
            if (mem_we) begin
                saw_we = 1'b1;
                check(mem_addr == w[11:0], "R8 link address", {20'd0, mem_addr}, {20'd0, w[11:0]});
                check(mem_wdata == {12'd0, model_pc + 12'd1}, "R8 link data",
                      {8'd0, mem_wdata}, {20'd0, model_pc + 12'd1});
            end
            @(negedge clk);
            guard++;
        end
        check(saw_we == is_call, is_call ? "R8 link strobe" : "R9 no strobe",
              {31'd0, saw_we}, {31'd0, is_call});
        check(fetch_req && fetch_addr == exp_pc, {req_of(w[23:18]), " ", tag},
              {19'd0, fetch_req, fetch_addr}, {19'd0, 1'b1, exp_pc});
        model_pc = exp_pc;
    endtask

    // called at a negedge with fetch_req high
    task automatic issue(input logic [23:0] w, input logic [23:0] a, input logic [23:0] q,
                         input int lat, input string tag);
        @(negedge clk);
        repeat (lat) @(negedge clk);
        drive_collect(w, a, q, tag);
    endtask

    function automatic logic [23:0] mk(input logic [5:0] fn, input logic [5:0] sh,
                                       input logic [11:0] ad);
        return {fn, sh, ad};
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; instr_valid = 1'b0; instr = '0; acc = '0; quo = '0;
        model_pc = '0;
        repeat (3) @(negedge clk);
        check(fetch_req && fetch_addr == 12'd0 && !mem_we, "R1 reset state",
              {18'd0, fetch_req, mem_we, fetch_addr}, {18'd0, 2'b10, 12'd0});
        rst = 1'b0;

        // R3 sequential step and R2 shift field ignored
        issue(mk(6'o00, 6'o00, 12'h123), 24'd0, 24'd0, 0, "plain step");
        issue(mk(6'o10, 6'o42, 12'h777), 24'd0, 24'd0, 2, "R2 shift holds a jump code");
        // R4 accumulator zero test
        issue(mk(6'o42, 6'o77, 12'h200), 24'd0, 24'hFFFFFF, 1, "R2 R4 zero taken");
        issue(mk(6'o42, 6'o00, 12'h300), 24'd1, 24'd0, 0, "zero not taken bit0");
        issue(mk(6'o42, 6'o00, 12'h300), 24'h800000, 24'd0, 0, "zero not taken sign");
        // R5 quotient zero test
        issue(mk(6'o45, 6'o00, 12'h400), 24'd5, 24'd0, 0, "quo zero taken");
        issue(mk(6'o45, 6'o00, 12'h500), 24'd0, 24'h000001, 3, "quo nonzero");
        // R6 / R7 sign tests
        issue(mk(6'o43, 6'o00, 12'h0A0), 24'd0, 24'd0, 0, "positive zero");
        issue(mk(6'o43, 6'o00, 12'h0B0), 24'h800000, 24'd0, 0, "negative skip");
        issue(mk(6'o44, 6'o00, 12'h0C0), 24'h800000, 24'd0, 1, "negative taken");
        issue(mk(6'o44, 6'o00, 12'h0D0), 24'h7FFFFF, 24'd0, 0, "positive skip");
        // R3 wrap via a jump to the last word
        issue(mk(6'o42, 6'o00, 12'hFFF), 24'd0, 24'd0, 0, "jump to top");
        issue(mk(6'o01, 6'o00, 12'h000), 24'd9, 24'd9, 0, "wrap to zero");
        // R8 call with link, and a call to the last word
        issue(mk(6'o47, 6'o05, 12'h640), 24'd3, 24'd3, 0, "call");
        issue(mk(6'o47, 6'o00, 12'hFFF), 24'd0, 24'd0, 2, "call wraps");

        // R10 a word shown during the request pulse is ignored
        acc = '0; instr = mk(6'o42, 6'o00, 12'h555); instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        check(!fetch_req && fetch_addr == model_pc, "R10 early word ignored",
              {19'd0, fetch_req, fetch_addr}, {19'd0, 1'b0, model_pc});
        @(negedge clk);
        check(!fetch_req && fetch_addr == model_pc, "R10 still waiting",
              {19'd0, fetch_req, fetch_addr}, {19'd0, 1'b0, model_pc});
        drive_collect(mk(6'o00, 6'o00, 12'h000), 24'd0, 24'd0, "after early word");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [5:0]  fn;
            logic [23:0] a;
            logic [23:0] q;
            int          sel;
            sel = $urandom % 9;
            case (sel)
                0: fn = 6'o42;
                1: fn = 6'o43;
                2: fn = 6'o44;
                3: fn = 6'o45;
                4: fn = 6'o47;
                default: fn = 6'($urandom);
            endcase
            a = ($urandom % 3 == 0) ? 24'd0 : 24'($urandom);
            q = ($urandom % 3 == 0) ? 24'd0 : 24'($urandom);
            issue(mk(fn, 6'($urandom), 12'($urandom)), a, q, $urandom % 4, "random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule